// File: doc/BRIEF.md
# Transmit Frame Builder

This block turns a payload that the host has already placed in a word-wide transmit buffer into a complete outgoing frame. The frame leaves as a byte stream with a valid/ready handshake, ready for the serializer that follows. The host gives a payload length and pulses a start strobe. The block then reads the buffer one word at a time through its own read port and splits each word into bytes. In order, it emits a fixed preamble, a start-of-frame delimiter, a length byte, the payload, and a two-byte check sequence that it computes itself. One pulse on the done output marks the end of the frame, and the host interrupt is wired to that pulse.

The buffer read port is combinational: the word at `buf_addr_o` must appear on `buf_rdata_i` in the same cycle. The buffer must not change while a frame is being sent.

Top module: `txf_framer`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` and `done_o` are low until a start strobe is taken.
- R2: A frame begins with four bytes of 0x00, followed by one delimiter byte of 0xA7.
- R3: The byte after the delimiter equals the payload length plus 2, so that it counts the check sequence.
- R4: Payload byte k is read from buffer word k/2. An even k takes bits [7:0] of that word and an odd k takes bits [15:8]. With an odd length, the unused high byte of the last word is never sent.
- R5: The last two bytes are a CRC-16 over the payload bytes only. The polynomial is x^16+x^12+x^5+1, the initial value is zero, bits are taken LSB first (reflected constant 0x8408), and the low byte of the CRC is sent first.
- R6: A requested length above 125 is clamped to 125, giving a length byte of 127 and 125 payload bytes.
- R7: A length of zero produces the header, a length byte of 2, and a check sequence of 0x0000.
- R8: While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `byte_o` holds its value. Every byte is sent exactly once.
- R9: `done_o` is high for exactly one cycle, in the cycle after the handshake that takes the final check-sequence byte. `valid_o` is low in that same cycle.
- R10: A start strobe that arrives while a frame is in progress has no effect: the running frame completes unchanged, and no second frame follows.
- R11: `valid_o` rises in the cycle after a start strobe is taken, and carries the first preamble byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| len_i | input | 7 | Requested payload length in bytes |
| buf_addr_o | output | 6 | Word address into the transmit buffer |
| buf_rdata_i | input | 16 | Buffer word at `buf_addr_o`, same cycle |
| byte_o | output | 8 | Outgoing frame byte |
| valid_o | output | 1 | `byte_o` is valid |
| ready_i | input | 1 | Downstream accepts `byte_o` |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench covers several payload sizes. An odd length exposes a design that sends the stale high byte of the last word. A zero length exposes a design that enters the payload phase anyway and emits garbage or a wrong check sequence. An oversized length shows whether a design wraps the length or forgets to clamp it.

A standard nine-byte check string pins down the CRC bit order and the byte order. A swapped or unreflected CRC gives a different pair of trailing bytes.

Irregular back-pressure catches a design that advances or drops bytes while `ready_i` is low. A start strobe injected mid-frame catches a design that restarts or queues a second frame. The done check catches a pulse that is late or lasts more than one cycle.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SFD,
    PH_LEN,
    PH_PAY,
    PH_FCS_LO,
    PH_FCS_HI
  } phase_e;
endpackage

// File: rtl/txf_crc16.sv
module txf_crc16 #(
  parameter logic [15:0] POLY_REFL = 16'h8408
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  din_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, crc_d;

  // next value: eight reflected shift steps, LSB of the data first
  always_comb begin
    logic [15:0] c;
    c = crc_q;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ din_i[b]) c = (c >> 1) ^ POLY_REFL;
      else                 c = c >> 1;
    end
    crc_d = c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
#(
  parameter int LEN_W   = 7,
  parameter int MAX_LEN = 125,
  parameter int PRE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             xfer_i,
  output phase_e           phase_o,
  output logic [LEN_W-1:0] idx_o,
  output logic [LEN_W-1:0] len_o,
  output logic             done_o,
  output logic             crc_clr_o,
  output logic             crc_en_o
);
  localparam int PRE_W = $clog2(PRE_LEN + 1);

  phase_e           ph_q, ph_d;
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] idx_q, idx_d, len_q, len_d;
  logic             done_q, done_d;
  logic             take;

  assign take = (ph_q == PH_IDLE) && start_i;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    len_d  = len_q;
    done_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_d  = PH_PRE;
        cnt_d = '0;
        idx_d = '0;
        len_d = (len_i > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_i;
      end
      PH_PRE: if (xfer_i) begin
        if (cnt_q == PRE_W'(PRE_LEN - 1)) ph_d = PH_SFD;
        else cnt_d = cnt_q + 1'b1;
      end
      PH_SFD: if (xfer_i) ph_d = PH_LEN;
      PH_LEN: if (xfer_i) ph_d = (len_q == '0) ? PH_FCS_LO : PH_PAY;
      PH_PAY: if (xfer_i) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == len_q - 1'b1) ph_d = PH_FCS_LO;
      end
      PH_FCS_LO: if (xfer_i) ph_d = PH_FCS_HI;
      PH_FCS_HI: if (xfer_i) begin
        ph_d   = PH_IDLE;
        done_d = 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= done_d;
      if (take || xfer_i) cnt_q <= cnt_d;
      if (take || xfer_i) idx_q <= idx_d;
      if (take)           len_q <= len_d;
    end
  end

  assign phase_o   = ph_q;
  assign idx_o     = idx_q;
  assign len_o     = len_q;
  assign done_o    = done_q;
  assign crc_clr_o = take;
  assign crc_en_o  = (ph_q == PH_PAY) && xfer_i;
endmodule

// File: rtl/txf_framer.sv
module txf_framer
  import txf_pkg::*;
#(
  parameter int          WORD_W   = 16,
  parameter int          DEPTH    = 64,
  parameter int          LEN_W    = 7,
  parameter int          MAX_LEN  = 125,
  parameter int          PRE_LEN  = 4,
  parameter logic [7:0]  PRE_BYTE = 8'h00,
  parameter logic [7:0]  SFD_BYTE = 8'hA7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [$clog2(DEPTH)-1:0] buf_addr_o,
  input  logic [WORD_W-1:0] buf_rdata_i,
  output logic [7:0]        byte_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              done_o
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);

  phase_e           phase;
  logic [LEN_W-1:0] idx, len_q;
  logic             crc_clr, crc_en, xfer;
  logic [15:0]      crc;
  logic [7:0]       lane [LANES];

  assign valid_o = (phase != PH_IDLE);
  assign xfer    = valid_o && ready_i;

  txf_ctrl #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .PRE_LEN(PRE_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .xfer_i(xfer), .phase_o(phase), .idx_o(idx), .len_o(len_q),
    .done_o(done_o), .crc_clr_o(crc_clr), .crc_en_o(crc_en)
  );

  txf_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr_i(crc_clr), .en_i(crc_en),
    .din_i(byte_o), .crc_o(crc)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = buf_rdata_i[g*8 +: 8];
  end

  assign buf_addr_o = ADDR_W'(idx >> LANE_W);

  always_comb begin
    unique case (phase)
      PH_PRE:    byte_o = PRE_BYTE;
      PH_SFD:    byte_o = SFD_BYTE;
      PH_LEN:    byte_o = 8'(len_q) + 8'd2;
      PH_PAY:    byte_o = lane[idx[LANE_W-1:0]];
      PH_FCS_LO: byte_o = crc[7:0];
      PH_FCS_HI: byte_o = crc[15:8];
      default:   byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/txf_framer_chk.sv
module txf_framer_chk #(
  parameter int MAX_LEN = 125
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [5:0] buf_addr_o,
  input logic [7:0] byte_o,
  input logic       valid_o,
  input logic       ready_i,
  input logic       done_o
);
  localparam int LAST_WORD = (MAX_LEN - 1) / 2;

  // R1
  always @(posedge clk) if (!rst_n) reset_quiet_chk: assert (!valid_o && !done_o);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(byte_o)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(valid_o && ready_i) && !valid_o));

  // R9
  end_marks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_o) |-> done_o);

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(buf_addr_o) <= LAST_WORD));

  // R11
  start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && start_i) |=> valid_o);
endmodule

bind txf_framer txf_framer_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .buf_addr_o(buf_addr_o),
  .byte_o(byte_o), .valid_o(valid_o), .ready_i(ready_i), .done_o(done_o)
);

// File: tb/txf_framer_tb.sv
module txf_framer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        start_i = 1'b0;
  logic [6:0]  len_i = '0;
  logic [5:0]  buf_addr_o;
  logic [15:0] buf_rdata_i;
  logic [7:0]  byte_o;
  logic        valid_o;
  logic        ready_i = 1'b0;
  logic        done_o;

  logic [15:0] mem [64];
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign buf_rdata_i = mem[buf_addr_o];

  txf_framer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .buf_addr_o(buf_addr_o), .buf_rdata_i(buf_rdata_i), .byte_o(byte_o),
    .valid_o(valid_o), .ready_i(ready_i), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [7:0] d [136], input int from, input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ d[from+i][b];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return c;
  endfunction

  function automatic logic [7:0] pay_byte(input int k);
    logic [15:0] w = mem[k/2];
    return (k % 2 == 0) ? w[7:0] : w[15:8];
  endfunction

  // Sends one frame and checks it byte by byte, plus handshake and done timing.
  task automatic run_frame(input int req_len, input bit stall, input int inj,
                           input string pay_req);
    logic [7:0] exp [136];
    logic [15:0] c;
    logic [7:0] held;
    bit hold_pend = 0;
    int got = 0;
    int cyc = 0;
    int plen = (req_len > 125) ? 125 : req_len;
    int n = 8 + plen;
    bit r;
    for (int i = 0; i < 4; i++) exp[i] = 8'h00;
    exp[4] = 8'hA7;
    exp[5] = 8'(plen + 2);
    for (int k = 0; k < plen; k++) exp[6+k] = pay_byte(k);
    c = crc_ref(exp, 6, plen);
    exp[6+plen] = c[7:0];
    exp[7+plen] = c[15:8];

    @(negedge clk); len_i = 7'(req_len); start_i = 1'b1; ready_i = 1'b0;
    @(negedge clk); start_i = 1'b0; #1;
    check(valid_o === 1'b1 && byte_o === 8'h00, "R11 first byte", {valid_o, byte_o}, 9'h100);
    while (got < n && cyc < 3000) begin
      if (hold_pend)
        check(valid_o === 1'b1 && byte_o === held, "R8 hold", byte_o, held);
      r = stall ? ((cyc % 3) != 1) : 1'b1;
      ready_i = r;
      if (cyc == inj) begin start_i = 1'b1; len_i = 7'd3; end
      #1;
      if (!valid_o) check(1'b0, "R8 valid dropped", got, n);
      else if (r) begin
        check(byte_o === exp[got],
              (got < 5) ? "R2 header" : (got == 5) ? "R3 length" :
              (got < 6 + plen) ? pay_req : "R5 fcs", byte_o, exp[got]);
        got++;
        hold_pend = 0;
      end else begin
        hold_pend = 1;
        held = byte_o;
      end
      @(negedge clk); start_i = 1'b0; #1;
      cyc++;
    end
    ready_i = 1'b0;
    check(got == n, "R8 byte count", got, n);
    check(done_o === 1'b1 && valid_o === 1'b0, "R9 done after last byte", {done_o, valid_o}, 2'b10);
    @(negedge clk); #1;
    check(done_o === 1'b0 && valid_o === 1'b0, "R9 R10 quiet after frame", {done_o, valid_o}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(valid_o === 1'b0 && done_o === 1'b0, "R1 in reset", {valid_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(valid_o === 1'b0 && done_o === 1'b0, "R1 after reset", {valid_o, done_o}, 0);
  endtask

  task automatic t_even();      run_frame(6,   1'b0, -1, "R4 even");     endtask
  task automatic t_odd_stall(); run_frame(7,   1'b1, -1, "R4 R8 odd");   endtask
  task automatic t_zero();      run_frame(0,   1'b1, -1, "R7 zero");     endtask
  task automatic t_clamp();     run_frame(127, 1'b1, -1, "R6 clamp");    endtask
  task automatic t_midstart();  run_frame(10,  1'b0, 8,  "R10 payload"); endtask

  task automatic t_crc_vector();
    mem[0] = {"2", "1"}; mem[1] = {"4", "3"}; mem[2] = {"6", "5"};
    mem[3] = {"8", "7"}; mem[4] = {8'hEE, "9"};
    begin
      logic [7:0] tail [2];
      int k = 0;
      @(negedge clk); len_i = 7'd9; start_i = 1'b1; ready_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      for (int i = 0; i < 40 && k < 2; i++) begin
        #1;
        if (valid_o && i >= 15) begin tail[k] = byte_o; k++; end
        @(negedge clk);
      end
      ready_i = 1'b0;
      // R5: check string over "123456789" gives 0x2189, low byte first
      check(k == 2 && tail[0] === 8'h89, "R5 vector low", tail[0], 8'h89);
      check(k == 2 && tail[1] === 8'h21, "R5 vector high", tail[1], 8'h21);
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = {8'(i * 13 + 1), 8'(i * 7 + 3)};
    #3 rst_n = 1'b0;
    t_reset();
    t_even();
    t_odd_stall();
    t_zero();
    t_clamp();
    t_midstart();
    t_crc_vector();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule